// File: doc/BRIEF.md
# Command Queue Consumer Engine

This block drains a ring of commands kept in memory. Software writes 16-byte entries into the ring and moves a producer pointer forward. While the engine is enabled and the ring holds work, it fetches the entry at the consumer index as four 32-bit beats over a simple request/response read port. It then classifies the opcode in the low byte of the first word. A recognised maintenance command is retired with no further action. A synchronisation command is retired and can raise a completion pulse. Anything else is a command error.

The consumer pointer moves forward only once a command has finished cleanly. A read fault or an unknown opcode writes an error code into a field of the consumer register. It also toggles the command-error bit in the global error vector and pulses the global error interrupt. The engine then stops fetching. It resumes, starting again at the same failed entry, once software writes the matching acknowledge bit.

Top module: `cmdq_consumer`

## Requirements
- R1: While reset is held and after its release, cons_ptr and gerr_vec read zero, and rd_req, sync_irq and gerr_irq are low.
- R2: No read request is issued while q_enable is low, or while cons_ptr[LOG2_SIZE:0] equals prod_ptr (ring empty).
- R3: Each command is fetched with exactly one rd_req cycle at rd_addr = base_addr + 16 × cons_ptr[LOG2_SIZE-1:0]. Four rd_rvalid beats follow, the opcode word first.
- R4: The opcodes 0x01–0x06, 0x10–0x13, 0x18, 0x1A, 0x20–0x23, 0x28, 0x2A, 0x30, 0x40, 0x41, 0x44 and 0x45 (word0[7:0]) are retired. cons_ptr[LOG2_SIZE:0] then rises by exactly one modulo 2^(LOG2_SIZE+1), so bit LOG2_SIZE acts as the wrap flag.
- R5: Opcode 0x46 (sync) is retired. sync_irq gives a single one-cycle pulse if word0 bit 12 (the low bit of the signal field at bits 13:12) is set, and no pulse otherwise.
- R6: Any other opcode, 0x00 and 0x47 included, writes code 1 into cons_ptr[30:24] and leaves the consumer index unchanged. gerr_vec[0] toggles and gerr_irq pulses for one cycle, in the same cycle that the field changes.
- R7: rd_rfault on the fourth beat writes code 2 into cons_ptr[30:24] whatever the opcode. Otherwise the error behaves as in R6: the index is not advanced, gerr_vec[0] toggles and gerr_irq pulses.
- R8: While gerr_vec[0] differs from gerr_ack[0], no read is issued. Once software makes them equal, fetching restarts at the same failed index.
- R9: cons_ptr[30:24] keeps the last error code through later successful commands and changes only in a cycle where gerr_irq is high.
- R10: Bits of word0 other than 7:0 and 12 have no effect: 0xFFFF0006 retires like 0x06.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_enable | input | 1 | Ring processing enable |
| base_addr | input | ADDR_W | Byte address of ring entry 0 |
| prod_ptr | input | LOG2_SIZE+1 | Producer index with wrap flag on top |
| cons_ptr | output | 32 | Consumer index with wrap flag in [LOG2_SIZE:0], error code in [30:24] |
| gerr_vec | output | GERR_W | Global error vector; bit CMD_ERR_BIT toggles on a command error |
| gerr_ack | input | GERR_W | Acknowledge vector; a bit equal to gerr_vec means not pending |
| rd_req | output | 1 | One-cycle read request for one entry |
| rd_addr | output | ADDR_W | Entry byte address, valid with rd_req |
| rd_rvalid | input | 1 | Read data beat valid |
| rd_rdata | input | 32 | Read data beat |
| rd_rfault | input | 1 | Fault flag, sampled on the last beat |
| sync_irq | output | 1 | Sync completion pulse |
| gerr_irq | output | 1 | Global error pulse |

## Verification
The producer pointer can move in the very cycle that the engine retires a command and checks the ring for emptiness again. The bench writes two entries and bumps the producer for the second one after a delay swept from 0 to 11 cycles, so every stage of the first command is hit, including the advance and idle cycles. Each run is judged by the final consumer index, the number of read requests and the sync pulse count. A lost or doubled fetch in any one of those cycles shows up as a wrong count.

// File: rtl/cmdq_pkg.sv
`timescale 1ns/1ps
package cmdq_pkg;

  localparam int CQ_WORD_W      = 32;
  localparam int CQ_ENTRY_BEATS = 4;
  localparam int CQ_ENTRY_SHIFT = 4;   // 16-byte entries
  localparam int CQ_ERR_LSB     = 24;
  localparam int CQ_ERR_W       = 7;

  localparam logic [7:0] CQ_OP_SYNC = 8'h46;
  localparam int         CQ_SIG_BIT = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_DECODE,
    ST_ADVANCE,
    ST_ERROR
  } cq_state_e;

  typedef enum logic [CQ_ERR_W-1:0] {
    CQ_ERR_NONE    = 7'd0,
    CQ_ERR_ILLEGAL = 7'd1,
    CQ_ERR_ABORT   = 7'd2
  } cq_err_e;

  // Opcodes that are recognised and retired with no side effect.
  function automatic logic cq_op_is_retire(input logic [7:0] op);
    logic r;
    case (op) inside
      [8'h01:8'h06], [8'h10:8'h13], 8'h18, 8'h1A,
      [8'h20:8'h23], 8'h28, 8'h2A, 8'h30,
      8'h40, 8'h41, 8'h44, 8'h45: r = 1'b1;
      default:                    r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cmdq_opcode_decoder.sv
`timescale 1ns/1ps
module cmdq_opcode_decoder
  import cmdq_pkg::*;
(
  input  logic [CQ_WORD_W-1:0] word0_i,
  output logic                 legal_o,
  output logic                 sync_sig_o
);

  logic [7:0] op;
  logic       is_sync;
  logic [CQ_WORD_W-1:0] unused_word0;

  assign op           = word0_i[7:0];
  assign is_sync      = (op == CQ_OP_SYNC);
  assign legal_o      = is_sync | cq_op_is_retire(op);
  assign sync_sig_o   = is_sync & word0_i[CQ_SIG_BIT];
  assign unused_word0 = word0_i;

endmodule

// File: rtl/cmdq_beat_collector.sv
`timescale 1ns/1ps
module cmdq_beat_collector #(
  parameter int BEATS = 4,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          collect_i,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  input  logic          fault_i,
  output logic [DW-1:0] word0_o,
  output logic          done_o,
  output logic          fault_o
);

  localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic [DW-1:0] word0_q;
  logic          take;
  logic          take_first;

  assign take       = collect_i & valid_i;
  assign take_first = take & (cnt_q == '0);
  assign done_o     = take & (cnt_q == LAST);
  assign fault_o    = done_o & fault_i;
  assign word0_o    = word0_q;

  assign cnt_en = arm_i | take;

  always_comb begin
    if (arm_i) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          word0_q <= '0;
    else if (take_first) word0_q <= data_i;
  end

endmodule

// File: rtl/cmdq_ring_ptr.sv
`timescale 1ns/1ps
module cmdq_ring_ptr
  import cmdq_pkg::*;
#(
  parameter int LOG2_SIZE = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LOG2_SIZE:0]   prod_i,
  input  logic                 adv_i,
  input  logic                 err_we_i,
  input  logic [CQ_ERR_W-1:0]  err_code_i,
  output logic [31:0]          cons_o,
  output logic [LOG2_SIZE-1:0] idx_o,
  output logic                 empty_o
);

  localparam int PW = LOG2_SIZE + 1;

  logic [PW-1:0]       ptr_q, ptr_d;
  logic [CQ_ERR_W-1:0] err_q, err_d;

  assign ptr_d   = ptr_q + 1'b1;   // index and wrap flag roll together
  assign err_d   = err_code_i;
  assign idx_o   = ptr_q[LOG2_SIZE-1:0];
  assign empty_o = (ptr_q == prod_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (adv_i) ptr_q <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_q <= '0;
    else if (err_we_i) err_q <= err_d;
  end

  always_comb begin
    cons_o = '0;
    cons_o[PW-1:0] = ptr_q;
    cons_o[CQ_ERR_LSB +: CQ_ERR_W] = err_q;
  end

endmodule

// File: rtl/cmdq_consumer.sv
`timescale 1ns/1ps
module cmdq_consumer
  import cmdq_pkg::*;
#(
  parameter int LOG2_SIZE   = 4,
  parameter int ADDR_W      = 32,
  parameter int GERR_W      = 8,
  parameter int CMD_ERR_BIT = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 q_enable,
  input  logic [ADDR_W-1:0]    base_addr,
  input  logic [LOG2_SIZE:0]   prod_ptr,
  output logic [31:0]          cons_ptr,
  output logic [GERR_W-1:0]    gerr_vec,
  input  logic [GERR_W-1:0]    gerr_ack,
  output logic                 rd_req,
  output logic [ADDR_W-1:0]    rd_addr,
  input  logic                 rd_rvalid,
  input  logic [CQ_WORD_W-1:0] rd_rdata,
  input  logic                 rd_rfault,
  output logic                 sync_irq,
  output logic                 gerr_irq
);

  cq_state_e state_q, state_d;
  cq_err_e   err_code_q, err_code_d;
  logic      gerr_q, gerr_d;
  logic      sync_irq_q, sync_irq_d;
  logic      gerr_irq_q, gerr_irq_d;

  logic                 arm, collect, adv, err_we;
  logic                 ring_empty;
  logic [LOG2_SIZE-1:0] cons_idx;
  logic [CQ_WORD_W-1:0] word0;
  logic                 beat_done, beat_fault;
  logic                 op_legal, op_sync_sig;
  logic                 cmd_err_pending;
  logic [GERR_W-1:0]    unused_ack;

  assign unused_ack      = gerr_ack;
  assign cmd_err_pending = gerr_q ^ gerr_ack[CMD_ERR_BIT];

  cmdq_ring_ptr #(.LOG2_SIZE(LOG2_SIZE)) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .prod_i     (prod_ptr),
    .adv_i      (adv),
    .err_we_i   (err_we),
    .err_code_i (err_code_q),
    .cons_o     (cons_ptr),
    .idx_o      (cons_idx),
    .empty_o    (ring_empty)
  );

  cmdq_beat_collector #(.BEATS(CQ_ENTRY_BEATS), .DW(CQ_WORD_W)) u_beats (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (arm),
    .collect_i (collect),
    .valid_i   (rd_rvalid),
    .data_i    (rd_rdata),
    .fault_i   (rd_rfault),
    .word0_o   (word0),
    .done_o    (beat_done),
    .fault_o   (beat_fault)
  );

  cmdq_opcode_decoder u_dec (
    .word0_i    (word0),
    .legal_o    (op_legal),
    .sync_sig_o (op_sync_sig)
  );

  assign rd_addr = base_addr + (ADDR_W'(cons_idx) << CQ_ENTRY_SHIFT);

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    err_code_d = err_code_q;
    gerr_d     = gerr_q;
    sync_irq_d = 1'b0;
    gerr_irq_d = 1'b0;
    rd_req     = 1'b0;
    arm        = 1'b0;
    collect    = 1'b0;
    adv        = 1'b0;
    err_we     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (q_enable && !ring_empty && !cmd_err_pending) state_d = ST_READ;
      end
      ST_READ: begin
        rd_req  = 1'b1;
        arm     = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        collect = 1'b1;
        if (beat_done) begin
          if (beat_fault) begin
            err_code_d = CQ_ERR_ABORT;
            state_d    = ST_ERROR;
          end else begin
            state_d = ST_DECODE;
          end
        end
      end
      ST_DECODE: begin
        if (op_legal) begin
          sync_irq_d = op_sync_sig;
          state_d    = ST_ADVANCE;
        end else begin
          err_code_d = CQ_ERR_ILLEGAL;
          state_d    = ST_ERROR;
        end
      end
      ST_ADVANCE: begin
        adv     = 1'b1;
        state_d = ST_IDLE;
      end
      ST_ERROR: begin
        err_we     = 1'b1;
        gerr_d     = ~gerr_q;
        gerr_irq_d = 1'b1;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      err_code_q <= CQ_ERR_NONE;
      gerr_q     <= 1'b0;
      sync_irq_q <= 1'b0;
      gerr_irq_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      err_code_q <= err_code_d;
      gerr_q     <= gerr_d;
      sync_irq_q <= sync_irq_d;
      gerr_irq_q <= gerr_irq_d;
    end
  end

  always_comb begin
    gerr_vec = '0;
    gerr_vec[CMD_ERR_BIT] = gerr_q;
  end

  assign sync_irq = sync_irq_q;
  assign gerr_irq = gerr_irq_q;

endmodule

// File: rtl/cmdq_consumer_chk.sv
`timescale 1ns/1ps
module cmdq_consumer_chk #(
  parameter int LOG2_SIZE   = 4,
  parameter int ADDR_W      = 32,
  parameter int GERR_W      = 8,
  parameter int CMD_ERR_BIT = 0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               q_enable,
  input logic [ADDR_W-1:0]  base_addr,
  input logic [LOG2_SIZE:0] prod_ptr,
  input logic [31:0]        cons_ptr,
  input logic [GERR_W-1:0]  gerr_vec,
  input logic [GERR_W-1:0]  gerr_ack,
  input logic               rd_req,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic               sync_irq,
  input logic               gerr_irq
);

  localparam int PW = LOG2_SIZE + 1;
  localparam logic [GERR_W-1:0] OTHER = ~(GERR_W'(1) << CMD_ERR_BIT);

  logic [PW-1:0]     cptr;
  logic [6:0]        efield;
  logic              pending;
  logic [31:0]       unused_cons;

  assign cptr        = cons_ptr[PW-1:0];
  assign efield      = cons_ptr[30:24];
  assign pending     = gerr_vec[CMD_ERR_BIT] != gerr_ack[CMD_ERR_BIT];
  assign unused_cons = cons_ptr;

  a_r2_disabled_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    !q_enable |=> !rd_req);

  a_r2_empty_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cptr == prod_ptr) |=> !rd_req);

  a_r3_req_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr == base_addr + (ADDR_W'(cptr[LOG2_SIZE-1:0]) << 4));

  a_r4_cons_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cptr) |-> cptr == PW'($past(cptr) + 1'b1));

  a_r5_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
    sync_irq |=> !sync_irq);

  a_r6_irq_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    gerr_irq |-> gerr_vec[CMD_ERR_BIT] != $past(gerr_vec[CMD_ERR_BIT]));

  a_r6_toggle_has_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gerr_vec[CMD_ERR_BIT]) |-> gerr_irq);

  a_r6_err_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    gerr_irq |-> efield != 7'd0 && $stable(cptr));

  a_r6_other_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (gerr_vec & OTHER) == '0);

  a_r8_pending_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> !rd_req);

  a_r9_err_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !gerr_irq |-> $stable(efield));

endmodule

bind cmdq_consumer cmdq_consumer_chk #(
  .LOG2_SIZE(LOG2_SIZE), .ADDR_W(ADDR_W), .GERR_W(GERR_W), .CMD_ERR_BIT(CMD_ERR_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .q_enable(q_enable), .base_addr(base_addr),
  .prod_ptr(prod_ptr), .cons_ptr(cons_ptr), .gerr_vec(gerr_vec), .gerr_ack(gerr_ack),
  .rd_req(rd_req), .rd_addr(rd_addr), .sync_irq(sync_irq), .gerr_irq(gerr_irq)
);

// File: tb/test_cmdq_consumer.sv
`timescale 1ns/1ps
module test_cmdq_consumer;

  localparam int L  = 4;
  localparam int PW = L + 1;
  localparam int AW = 32;
  localparam int GW = 8;
  localparam int NV = 20;
  localparam logic [AW-1:0] BASE = 32'h0000_4000;

  // [35:4] opcode word, [3] fault, [2:1] expected error code, [0] expected sync pulse
  localparam logic [35:0] VEC [NV] = '{
    {32'h0000_0001, 1'b0, 2'd0, 1'b0},  // R4 plain retire
    {32'h0000_0046, 1'b0, 2'd0, 1'b0},  // R5 sync, no signal
    {32'h0000_1046, 1'b0, 2'd0, 1'b1},  // R5 sync with signal
    {32'h0000_0099, 1'b0, 2'd1, 1'b0},  // R6 unknown opcode
    {32'h0000_0010, 1'b1, 2'd2, 1'b0},  // R7 fault on a legal opcode
    {32'h0000_0000, 1'b0, 2'd1, 1'b0},  // R6 opcode zero
    {32'h0000_002A, 1'b0, 2'd0, 1'b0},  // R4
    {32'h0000_2046, 1'b0, 2'd0, 1'b0},  // R5 signal field 2: no pulse
    {32'h0000_3046, 1'b0, 2'd0, 1'b1},  // R5 signal field 3: pulse
    {32'h0000_0007, 1'b0, 2'd1, 1'b0},  // R6 gap opcode
    {32'h0000_0018, 1'b0, 2'd0, 1'b0},  // R4
    {32'h0000_001A, 1'b0, 2'd0, 1'b0},  // R4
    {32'h0000_0019, 1'b0, 2'd1, 1'b0},  // R6
    {32'h0000_0030, 1'b0, 2'd0, 1'b0},  // R4
    {32'h0000_0040, 1'b0, 2'd0, 1'b0},  // R4
    {32'h0000_0041, 1'b0, 2'd0, 1'b0},  // R4
    {32'h0000_0044, 1'b0, 2'd0, 1'b0},  // R4 index wraps around here
    {32'h0000_0045, 1'b0, 2'd0, 1'b0},  // R4
    {32'hFFFF_0006, 1'b0, 2'd0, 1'b0},  // R10 upper bits ignored
    {32'h0000_0047, 1'b0, 2'd1, 1'b0}   // R6
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          q_enable;
  logic [AW-1:0] base_addr;
  logic [PW-1:0] prod_ptr;
  logic [31:0]   cons_ptr;
  logic [GW-1:0] gerr_vec;
  logic [GW-1:0] gerr_ack;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_rvalid;
  logic [31:0]   rd_rdata;
  logic          rd_rfault;
  logic          sync_irq;
  logic          gerr_irq;

  always #2 clk = ~clk;   // 250 MHz

  cmdq_consumer #(.LOG2_SIZE(L), .ADDR_W(AW), .GERR_W(GW), .CMD_ERR_BIT(0)) i_cmdq_consumer (
    .clk(clk), .rst_n(rst_n), .q_enable(q_enable), .base_addr(base_addr),
    .prod_ptr(prod_ptr), .cons_ptr(cons_ptr), .gerr_vec(gerr_vec), .gerr_ack(gerr_ack),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
    .rd_rfault(rd_rfault), .sync_irq(sync_irq), .gerr_irq(gerr_irq)
  );

  // Memory model
  logic [31:0]  op_mem  [16];
  logic         flt_mem [16];
  logic         busy;
  logic [1:0]   bcnt;
  logic [L-1:0] midx;
  logic [AW-1:0] off;
  int           n_reads = 0;
  logic [AW-1:0] last_addr;
  int           n_sync = 0;
  int           n_gerr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; bcnt <= 2'd0; midx <= '0;
      rd_rvalid <= 1'b0; rd_rfault <= 1'b0; rd_rdata <= '0;
      last_addr <= '0;
    end else begin
      rd_rvalid <= 1'b0;
      rd_rfault <= 1'b0;
      if (busy) begin
        rd_rvalid <= 1'b1;
        rd_rdata  <= (bcnt == 2'd0) ? op_mem[midx] : {24'hA5A5A5, 2'b00, midx, bcnt};
        rd_rfault <= (bcnt == 2'd3) && flt_mem[midx];
        bcnt      <= bcnt + 2'd1;
        if (bcnt == 2'd3) busy <= 1'b0;
      end
      if (rd_req) begin
        off       = rd_addr - BASE;
        busy      <= 1'b1;
        bcnt      <= 2'd0;
        midx      <= off[L+3:4];
        n_reads   <= n_reads + 1;
        last_addr <= rd_addr;
      end
      if (sync_irq) n_sync <= n_sync + 1;
      if (gerr_irq) n_gerr <= n_gerr + 1;
    end
  end

  int n_vec = 0;
  int n_mis = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_mis);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_mis++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  logic [PW-1:0] exp_cons;
  logic [6:0]    exp_err;
  logic          exp_g;

  initial begin
    logic [31:0]  w;
    logic         f;
    logic [1:0]   code;
    logic         sy;
    logic [L-1:0] idx;
    int           r0, s0, g0;

    rst_n = 1'b0; q_enable = 1'b0; base_addr = BASE; prod_ptr = '0; gerr_ack = '0;
    for (int i = 0; i < 16; i++) begin op_mem[i] = 32'h1; flt_mem[i] = 1'b0; end
    wait_cyc(3);
    chk("R1 cons in reset", cons_ptr, 32'h0);
    chk("R1 gerr in reset", 32'(gerr_vec), 32'h0);
    chk("R1 outputs in reset", {29'h0, rd_req, sync_irq, gerr_irq}, 32'h0);
    rst_n = 1'b1;
    wait_cyc(3);
    chk("R1 cons after reset", cons_ptr, 32'h0);
    chk("R1 outputs after reset", {29'h0, rd_req, sync_irq, gerr_irq}, 32'h0);
    q_enable = 1'b1;
    wait_cyc(4);
    chk("R2 empty ring no read", 32'(n_reads), 32'h0);

    exp_cons = '0; exp_err = '0; exp_g = 1'b0;

    for (int v = 0; v < NV; v++) begin
      w = VEC[v][35:4]; f = VEC[v][3]; code = VEC[v][2:1]; sy = VEC[v][0];
      idx = exp_cons[L-1:0];
      op_mem[idx] = w; flt_mem[idx] = f;
      r0 = n_reads; s0 = n_sync; g0 = n_gerr;
      prod_ptr = PW'(exp_cons + 1'b1);
      wait_cyc(14);
      chk("R3 one read per command", 32'(n_reads - r0), 32'h1);
      chk("R3 entry address", last_addr, BASE + {idx, 4'b0000});
      if (code == 2'd0) begin
        exp_cons = PW'(exp_cons + 1'b1);
        chk("R4 consumer advance", 32'(cons_ptr[PW-1:0]), 32'(exp_cons));
        chk("R5 sync pulse count", 32'(n_sync - s0), 32'(sy));
        chk("R9 error field kept", 32'(cons_ptr[30:24]), 32'(exp_err));
      end else begin
        exp_err = 7'(code);
        exp_g   = ~exp_g;
        chk("R6/R7 index held on error", 32'(cons_ptr[PW-1:0]), 32'(exp_cons));
        chk("R6/R7 error code", 32'(cons_ptr[30:24]), 32'(exp_err));
        chk("R6/R7 gerr bit toggled", 32'(gerr_vec[0]), 32'(exp_g));
        chk("R6/R7 gerr pulse", 32'(n_gerr - g0), 32'h1);
        r0 = n_reads;
        wait_cyc(6);
        chk("R8 no read while pending", 32'(n_reads - r0), 32'h0);
        op_mem[idx] = 32'h1; flt_mem[idx] = 1'b0;
        gerr_ack[0] = exp_g;
        wait_cyc(14);
        chk("R8 retry same address", last_addr, BASE + {idx, 4'b0000});
        exp_cons = PW'(exp_cons + 1'b1);
        chk("R8 resumed advance", 32'(cons_ptr[PW-1:0]), 32'(exp_cons));
        chk("R9 error field after success", 32'(cons_ptr[30:24]), 32'(exp_err));
      end
    end

    // R2: disabled engine leaves a non-empty ring alone
    q_enable = 1'b0;
    r0 = n_reads;
    op_mem[exp_cons[L-1:0]] = 32'h2;
    prod_ptr = PW'(exp_cons + 1'b1);
    wait_cyc(14);
    chk("R2 disabled no read", 32'(n_reads - r0), 32'h0);
    chk("R2 disabled no advance", 32'(cons_ptr[PW-1:0]), 32'(exp_cons));
    q_enable = 1'b1;
    wait_cyc(14);
    exp_cons = PW'(exp_cons + 1'b1);
    chk("R2 enable resumes", 32'(cons_ptr[PW-1:0]), 32'(exp_cons));

    // Producer moves at every stage of an in-flight command
    for (int d = 0; d < 12; d++) begin
      op_mem[exp_cons[L-1:0]] = 32'h0000_0003;
      op_mem[PW'(exp_cons + 1'b1) & PW'(15)] = 32'h0000_1046;
      r0 = n_reads; s0 = n_sync;
      prod_ptr = PW'(exp_cons + 1'b1);
      wait_cyc(d);
      prod_ptr = PW'(exp_cons + 2'd2);
      wait_cyc(30);
      exp_cons = PW'(exp_cons + 2'd2);
      chk("R4 overlap consumer", 32'(cons_ptr[PW-1:0]), 32'(exp_cons));
      chk("R3 overlap reads", 32'(n_reads - r0), 32'h2);
      chk("R5 overlap sync", 32'(n_sync - s0), 32'h1);
    end

    finish_run();
  end

endmodule